// File: doc/BRIEF.md
# Decoupled SIMD Issue Queue Controller

This controller couples an in-order integer issue stage to a SIMD execution unit that runs on its own timeline. The integer stage may offer one operation per clock. Register-to-register SIMD operations are written into a short in-order queue. The queue feeds an execution model that accepts a new operation only every other cycle, and each operation's result appears a fixed number of cycles after it starts. Each retiring operation produces a one-cycle completion pulse that carries its tag.

Transfers between the integer and SIMD register files bypass the queue and use a separate transfer unit. A load from a 32-bit integer register waits until no in-flight operation writes its target register and until no other transfer is in flight. It then holds the integer stage for its scheduling window. An insert-style load also spends extra execute cycles, during which independent SIMD work may keep flowing. A store to a 32-bit integer register waits until its SIMD source has no pending write. It then holds the integer stage for a long fixed interval while the queue keeps draining. A per-register pending-write scoreboard drives these interlocks, and one combinational stall output reports them to the integer stage.

Top module: `simd_issue_ctrl`

## Requirements
- R1: An operation is accepted at a clock edge when `valid_i`=1 and `stall_o`=0 in the cycle before that edge. `stall_o` is 0 whenever `valid_i`=0. After reset, `stall_o`, `q_done_o` and `xfer_done_o` are 0.
- R2: Operation classes are encoded in `cls_i` as 0 = normal, 1 = plain move load, 2 = word-insert load and 3 = store. Normal ops are buffered in a queue of 6 entries. An offered normal op stalls while 6 entries are buffered.
- R3: Normal ops start in order, at most one every 2 cycles. A normal op accepted at edge P into an idle, empty controller shows `q_done_o`=1 with its tag in the cycle after edge P+6. Later ops of an unbroken burst retire 2 cycles apart, in acceptance order.
- R4: When normal ops are offered continuously into an empty controller, the first 11 are accepted on consecutive edges P..P+10. The 12th is accepted at P+12.
- R5: A load, whose target is `dst_i`, is accepted only when no other transfer is in flight and the target has no pending write. Any op offered after a load accepted at edge P is stalled until edge P+5. A move load shows `xfer_done_o` after edge P+4, and an insert load shows it after edge P+8.
- R6: During an insert load's execute phase, a normal op whose `src_i` and `dst_i` both differ from the load target is accepted at once. A normal op that names the load target is accepted at the second edge after the `xfer_done_o` cycle.
- R7: A store, whose source is `src_i`, stalls while its source has a pending write. Once it is accepted at edge S, every op offered afterwards stalls through the cycle after edge S+9. In that cycle `xfer_done_o` is 1 with the store's tag, and the next op is accepted at S+11.
- R8: Queued normal ops keep starting and retiring on their normal schedule while a store executes. Their `q_done_o` pulses may fall in the same cycle as the store's `xfer_done_o`.
- R9: A register's pending-write count rises when a normal op or load that writes it is accepted, and falls when that op retires. A load or store blocked on a register whose last writer shows `q_done_o` after edge D is accepted at edge D+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Integer stage offers an operation |
| cls_i | input | 2 | Operation class (0 normal, 1 move load, 2 insert load, 3 store) |
| dst_i | input | 3 | SIMD destination register (normal op, load) |
| src_i | input | 3 | SIMD source register (normal op, store) |
| tag_i | input | 6 | Tag returned at retirement |
| stall_o | output | 1 | Offered operation is not accepted this cycle |
| q_done_o | output | 1 | A queued normal op retires |
| q_tag_o | output | 6 | Tag of the retiring normal op |
| xfer_done_o | output | 1 | A load or store retires |
| xfer_tag_o | output | 6 | Tag of the retiring transfer |

## Verification
A queued normal op can retire in the same cycle as a store held in the transfer unit. Both results must appear, each on its own output, and neither may delay the other. To provoke this, five normal ops are accepted back to back and a store on an untouched register is accepted on the next edge. That places the last queue retirement on the same cycle as the store completion. The bench predicts each retirement edge from the 2-cycle start spacing, the 6-cycle latency and the 10-cycle store time, and then checks both the edge and the tag of every pulse.

// File: rtl/simd_q_pkg.sv
package simd_q_pkg;
  parameter int unsigned REG_N = 8;
  parameter int unsigned REG_W = $clog2(REG_N);
  parameter int unsigned TAG_W = 6;

  typedef enum logic [1:0] {
    OP_NORM = 2'd0,
    OP_MOVL = 2'd1,
    OP_INSL = 2'd2,
    OP_STOR = 2'd3
  } op_cls_e;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [REG_W-1:0] dst;
  } q_entry_t;
endpackage

// File: rtl/simd_op_fifo.sv
module simd_op_fifo
  import simd_q_pkg::*;
#(
  parameter int unsigned DEPTH = 6
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     push_i,
  input  q_entry_t push_data_i,
  input  logic     pop_i,
  output q_entry_t head_o,
  output logic     empty_o,
  output logic     full_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  q_entry_t         mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= ptr_next(wr_q);
      if (pop_i)  rd_q <= ptr_next(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o || pop_i);
  assert_no_underflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/simd_exec_pipe.sv
module simd_exec_pipe
  import simd_q_pkg::*;
#(
  parameter int unsigned LAT = 6,
  parameter int unsigned GAP = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     head_valid_i,
  input  q_entry_t head_i,
  output logic     issue_o,
  output logic     done_o,
  output q_entry_t done_entry_o
);
  localparam int unsigned GW = $clog2(GAP + 1);

  logic [GW-1:0] gap_q;
  logic [LAT-1:0] vld_q;
  q_entry_t       stg_q [LAT];

  assign issue_o = head_valid_i && (gap_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          gap_q <= '0;
    else if (issue_o)     gap_q <= GW'(GAP - 1);
    else if (gap_q != '0) gap_q <= gap_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q[0] <= 1'b0;
    else         vld_q[0] <= issue_o;
  end
  always_ff @(posedge clk_i) begin
    if (issue_o) stg_q[0] <= head_i;
  end

  for (genvar i = 1; i < LAT; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vld_q[i] <= 1'b0;
      else         vld_q[i] <= vld_q[i-1];
    end
    always_ff @(posedge clk_i) begin
      stg_q[i] <= stg_q[i-1];
    end
  end

  assign done_o       = vld_q[LAT-1];
  assign done_entry_o = stg_q[LAT-1];

  if (GAP > 1) begin : g_gap_chk
    assert_issue_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      issue_o |=> !issue_o);
  end
endmodule

// File: rtl/simd_scoreboard.sv
module simd_scoreboard
  import simd_q_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_en_i,
  input  logic [REG_W-1:0] inc_reg_i,
  input  logic             deca_en_i,
  input  logic [REG_W-1:0] deca_reg_i,
  input  logic             decb_en_i,
  input  logic [REG_W-1:0] decb_reg_i,
  output logic [REG_N-1:0] pend_o
);
  for (genvar r = 0; r < REG_N; r++) begin : g_reg
    logic [CNT_W-1:0] cnt_q;
    logic inc, deca, decb;
    assign inc  = inc_en_i  && (inc_reg_i  == REG_W'(r));
    assign deca = deca_en_i && (deca_reg_i == REG_W'(r));
    assign decb = decb_en_i && (decb_reg_i == REG_W'(r));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else cnt_q <= cnt_q + CNT_W'(inc) - CNT_W'(deca) - CNT_W'(decb);
    end
    assign pend_o[r] = (cnt_q != '0);

    assert_no_underflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (deca || decb) |-> cnt_q != '0);
  end
endmodule

// File: rtl/simd_xfer_unit.sv
module simd_xfer_unit
  import simd_q_pkg::*;
#(
  parameter int unsigned SCHED_CYC = 5,
  parameter int unsigned INS_CYC   = 4,
  parameter int unsigned STORE_CYC = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  op_cls_e          cls_i,
  input  logic [REG_W-1:0] reg_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             busy_o,
  output logic             block_o,
  output logic             is_load_o,
  output logic [REG_W-1:0] reg_o,
  output logic             done_o,
  output logic [TAG_W-1:0] done_tag_o
);
  localparam int unsigned LD_MAX = SCHED_CYC - 1 + INS_CYC;
  localparam int unsigned C_MAX  = (LD_MAX > STORE_CYC - 1) ? LD_MAX : STORE_CYC - 1;
  localparam int unsigned CW     = $clog2(C_MAX + 1);

  logic          busy_q, store_q;
  logic [CW-1:0] cnt_q, exec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      store_q <= 1'b0;
      cnt_q   <= '0;
      exec_q  <= '0;
      reg_o   <= '0;
      done_tag_o <= '0;
    end else if (start_i) begin
      busy_q     <= 1'b1;
      store_q    <= (cls_i == OP_STOR);
      reg_o      <= reg_i;
      done_tag_o <= tag_i;
      case (cls_i)
        OP_STOR: begin cnt_q <= CW'(STORE_CYC - 1);           exec_q <= '0; end
        OP_INSL: begin cnt_q <= CW'(SCHED_CYC - 1 + INS_CYC); exec_q <= CW'(INS_CYC); end
        default: begin cnt_q <= CW'(SCHED_CYC - 1);           exec_q <= '0; end
      endcase
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o    = busy_q;
  assign is_load_o = busy_q && !store_q;
  // store blocks for its whole life, a load only in its scheduling window
  assign block_o   = busy_q && (store_q || (cnt_q > exec_q));
  assign done_o    = busy_q && (cnt_q == '0);

  assert_single_xfer_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/simd_issue_ctrl.sv
module simd_issue_ctrl
  import simd_q_pkg::*;
#(
  parameter int unsigned DEPTH     = 6,
  parameter int unsigned LAT       = 6,
  parameter int unsigned GAP       = 2,
  parameter int unsigned SCHED_CYC = 5,
  parameter int unsigned INS_CYC   = 4,
  parameter int unsigned STORE_CYC = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       cls_i,
  input  logic [REG_W-1:0] dst_i,
  input  logic [REG_W-1:0] src_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             stall_o,
  output logic             q_done_o,
  output logic [TAG_W-1:0] q_tag_o,
  output logic             xfer_done_o,
  output logic [TAG_W-1:0] xfer_tag_o
);
  localparam int unsigned PEND_W = $clog2(DEPTH + LAT + 2);

  op_cls_e          cls;
  logic             full, empty, pop, accept, push, start;
  logic             x_busy, x_block, x_load;
  logic [REG_W-1:0] x_reg;
  logic [REG_N-1:0] pend;
  logic             cls_stall, ld_conflict;
  q_entry_t         head, done_ent, new_ent;

  assign cls = op_cls_e'(cls_i);

  assign ld_conflict = x_load && ((src_i == x_reg) || (dst_i == x_reg));

  always_comb begin
    unique case (cls)
      OP_NORM:          cls_stall = full || ld_conflict;
      OP_MOVL, OP_INSL: cls_stall = x_busy || pend[dst_i];
      default:          cls_stall = x_busy || pend[src_i];
    endcase
  end

  assign stall_o = valid_i && (x_block || cls_stall);
  assign accept  = valid_i && !stall_o;
  assign push    = accept && (cls == OP_NORM);
  assign start   = accept && (cls != OP_NORM);
  assign new_ent = '{tag: tag_i, dst: dst_i};

  simd_op_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk_i, .rst_ni,
    .push_i(push), .push_data_i(new_ent), .pop_i(pop),
    .head_o(head), .empty_o(empty), .full_o(full)
  );

  simd_exec_pipe #(.LAT(LAT), .GAP(GAP)) i_pipe (
    .clk_i, .rst_ni,
    .head_valid_i(!empty), .head_i(head), .issue_o(pop),
    .done_o(q_done_o), .done_entry_o(done_ent)
  );
  assign q_tag_o = done_ent.tag;

  simd_xfer_unit #(.SCHED_CYC(SCHED_CYC), .INS_CYC(INS_CYC), .STORE_CYC(STORE_CYC)) i_xfer (
    .clk_i, .rst_ni,
    .start_i(start), .cls_i(cls), .reg_i((cls == OP_STOR) ? src_i : dst_i), .tag_i(tag_i),
    .busy_o(x_busy), .block_o(x_block), .is_load_o(x_load), .reg_o(x_reg),
    .done_o(xfer_done_o), .done_tag_o(xfer_tag_o)
  );

  simd_scoreboard #(.CNT_W(PEND_W)) i_sb (
    .clk_i, .rst_ni,
    .inc_en_i(accept && (cls != OP_STOR)), .inc_reg_i(dst_i),
    .deca_en_i(q_done_o), .deca_reg_i(done_ent.dst),
    .decb_en_i(xfer_done_o && x_load), .decb_reg_i(x_reg),
    .pend_o(pend)
  );

  assert_stall_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !stall_o);
endmodule

// File: tb/test_simd_issue_ctrl.sv
module test_simd_issue_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [1:0] cls_i = '0;
  logic [2:0] dst_i = '0, src_i = '0;
  logic [5:0] tag_i = '0;
  logic       stall_o, q_done_o, xfer_done_o;
  logic [5:0] q_tag_o, xfer_tag_o;

  int checks = 0, fails = 0;
  int edge_n = 0;
  int q_n = 0, x_n = 0;
  int q_tag_a [64], q_edge_a [64], x_tag_a [16], x_edge_a [16];

  simd_issue_ctrl i_simd_issue_ctrl (.*);

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) edge_n <= edge_n + 1;

  always @(negedge clk_i) begin
    if (q_done_o && q_n < 64) begin q_tag_a[q_n] = q_tag_o; q_edge_a[q_n] = edge_n; q_n++; end
    if (xfer_done_o && x_n < 16) begin x_tag_a[x_n] = xfer_tag_o; x_edge_a[x_n] = edge_n; x_n++; end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, hold until accepted, return acceptance edge
  task automatic offer(input int cls, input int dst, input int src, input int tag, output int acc);
    valid_i = 1'b1; cls_i = 2'(cls); dst_i = 3'(dst); src_i = 3'(src); tag_i = 6'(tag);
    #1;
    while (stall_o) begin
      @(negedge clk_i); #1;
    end
    acc = edge_n + 1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    int p, a, b, qb, xb;
    int acc [16];
    repeat (3) @(negedge clk_i);
    check(stall_o == 0, "R1 reset stall", stall_o, 0);
    check(q_done_o == 0, "R1 reset q_done", q_done_o, 0);
    check(xfer_done_o == 0, "R1 reset xfer_done", xfer_done_o, 0);
    rst_ni = 1'b1;
    idle(2);

    // burst of normal ops
    qb = q_n;
    for (int k = 0; k < 14; k++) offer(0, k % 8, (k + 1) % 8, k, acc[k]);
    p = acc[0];
    for (int k = 1; k <= 10; k++)
      check(acc[k] == p + k, "R4 back-to-back accept", acc[k] - p, k);
    check(acc[11] == p + 12, "R2 queue full stall", acc[11] - p, 12);
    idle(40);
    check(q_n - qb == 14, "R3 all retired", q_n - qb, 14);
    for (int k = 0; k < 14; k++) begin
      check(q_tag_a[qb + k] == k, "R3 retire order", q_tag_a[qb + k], k);
      check(q_edge_a[qb + k] == p + 6 + 2 * k, "R3 retire timing", q_edge_a[qb + k] - p, 6 + 2 * k);
    end

    // loads
    xb = x_n;
    offer(1, 3, 0, 20, a);
    offer(2, 5, 0, 21, b);
    check(b == a + 6, "R5 load waits for load", b - a, 6);
    offer(0, 1, 2, 22, p);
    check(p == b + 5, "R6 independent op after schedule", p - b, 5);
    offer(0, 6, 5, 23, p);
    check(p == b + 10, "R6 dependent op waits", p - b, 10);
    idle(15);
    check(x_n - xb == 2, "R5 transfer retire count", x_n - xb, 2);
    check(x_edge_a[xb] == a + 4 && x_tag_a[xb] == 20, "R5 move load done", x_edge_a[xb] - a, 4);
    check(x_edge_a[xb + 1] == b + 8 && x_tag_a[xb + 1] == 21, "R5 insert load done", x_edge_a[xb + 1] - b, 8);
    idle(10);

    // load waits for pending write
    offer(0, 6, 0, 24, p);
    offer(1, 6, 0, 25, a);
    check(a == p + 8, "R9 load waits on pending write", a - p, 8);
    idle(15);

    // store waits, then blocks
    xb = x_n;
    offer(0, 2, 0, 26, p);
    offer(3, 0, 2, 27, a);
    check(a == p + 8, "R9 store waits on pending write", a - p, 8);
    offer(0, 4, 4, 28, b);
    check(b == a + 11, "R7 store blocks integer stage", b - a, 11);
    check(x_edge_a[xb] == a + 9 && x_tag_a[xb] == 27, "R7 store done", x_edge_a[xb] - a, 9);
    idle(15);

    // queue drains during store; collision of both done outputs
    qb = q_n; xb = x_n;
    for (int k = 0; k < 5; k++) offer(0, k, 7 - k, 30 + k, acc[k]);
    offer(3, 0, 7, 40, a);
    p = acc[0];
    check(a == p + 5, "R8 store accepted behind queue", a - p, 5);
    idle(20);
    for (int k = 0; k < 5; k++)
      check(q_edge_a[qb + k] == p + 6 + 2 * k && q_tag_a[qb + k] == 30 + k,
            "R8 queue retires during store", q_edge_a[qb + k] - p, 6 + 2 * k);
    check(x_edge_a[xb] == a + 9 && x_tag_a[xb] == 40, "R8 store done same cycle", x_edge_a[xb] - a, 9);
    check(x_edge_a[xb] == q_edge_a[qb + 4], "R8 coincident retire", x_edge_a[xb], q_edge_a[qb + 4]);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #160000;
    checks++; fails++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", edge_n, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule